// File: doc/BRIEF.md
# Descriptor Channel Control Sequencer

This block is the control engine of one descriptor-processing channel inside a security accelerator. It holds a 12-bit channel configuration word. The word selects the burst length and the address width, arms the completion writeback rules, and carries two self-clearing command bits: a full channel reset and a lighter "continue" reset. When a command bit is set, the sequencer runs a clean-up. The steps depend on where the channel stands with the execution-unit arbiter. A pending request is cancelled. Assigned units have their software reset bits written and are then released. In both cases the channel state is cleared and the sequencer drops back to idle.

At the end of every descriptor the block decides whether the descriptor header is written back to memory and whether that header carries the execution-unit status. The memory transfer itself, the crypto work and the descriptor parsing belong to neighbouring blocks. This block only issues the request strobes to them.

Top module: `chan_ctl_seq`

## Requirements
- R1: After synchronous reset the configuration reads 0x000, busy, eu_req, all release, write and strobe outputs are 0, burst_bytes is 64 and addr_bits is 32.
- R2: Configuration bits 4, 5, 8 and 9 are reserved. They always read 0 and writes to them are ignored.
- R3: Bit 6 selects the burst length: 0 gives burst_bytes = 64, 1 gives burst_bytes = 128.
- R4: Bit 7 selects the address width: 0 gives addr_bits = 32, 1 gives addr_bits = 36.
- R5: The cycle after desc_done is taken in the active state, hdr_wb_req pulses when bit 0 (done writeback) is 1 and either bit 3 (global notify) or desc_dn is 1. It also pulses whenever R6 asks for status.
- R6: hdr_wb_stat pulses together with hdr_wb_req when bit 1 (always status) is 1, in which case bit 2 has no effect. It also pulses when bit 2 (ICV status) is 1 and desc_icv is 1.
- R7: A command bit seen while eu_req is high drops eu_req and gives a one-cycle eu_rel_pri pulse with no unit write. The next cycle is the clear cycle, and the cycle after that is idle.
- R8: A command bit seen while a unit is assigned raises eu_wr_req with eu_wr_sec=0 and holds it until eu_wr_gnt. If a secondary unit was reserved, the same is then done with eu_wr_sec=1. Then eu_rel_pri pulses for one cycle, followed by eu_rel_sec for one cycle if a secondary unit was reserved, and finally the clear cycle.
- R9: Continue (bit 10) keeps configuration bits 5:0 and clears the rest. It never pulses fifo_clr and pulses resume in its clear cycle.
- R10: Reset (bit 11) clears the whole configuration and pulses fifo_clr in its clear cycle. A write with bits 11 and 10 both 1 stores only bit 11.
- R11: A configuration write is ignored while a command bit is pending or busy is high.
- R12: busy rises the cycle after a command bit is stored and stays high until the first idle cycle after the clear cycle. In that cycle bits 11:10 read 0.
- R13: A reset issued in idle goes straight to the clear cycle, then to idle, with no unit write or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Configuration read value |
| desc_start | input | 1 | Descriptor wants an execution unit |
| eu_gnt | input | 1 | Arbiter assigns the primary unit |
| sec_rsv | input | 1 | A secondary unit is reserved with the grant |
| desc_done | input | 1 | Descriptor processing complete |
| desc_dn | input | 1 | Header done-notification flag of the descriptor |
| desc_icv | input | 1 | Descriptor requested ICV comparison |
| eu_req | output | 1 | Unit request to the arbiter |
| eu_rel_pri | output | 1 | Release pulse, primary unit or cancelled request |
| eu_rel_sec | output | 1 | Release pulse, secondary unit |
| eu_wr_req | output | 1 | Unit software-reset write request |
| eu_wr_sec | output | 1 | Write targets the secondary unit |
| eu_wr_gnt | input | 1 | Write request accepted |
| fifo_clr | output | 1 | Fetch FIFO clear strobe |
| resume | output | 1 | Continue finished, fetch next pointer |
| hdr_wb_req | output | 1 | Header writeback request pulse |
| hdr_wb_stat | output | 1 | Header writeback includes unit status |
| busy | output | 1 | Reset or continue sequence in progress |
| burst_bytes | output | 8 | Selected burst length in bytes |
| addr_bits | output | 6 | Selected address width |

## Verification
The completion decision is driven with a table of enable and flag combinations. The table separates the done-writeback path from the global-notify path and the per-descriptor notify path. It also shows that the always-status bit overrides the ICV-only bit, and that an ICV flag without its enable does nothing. The reset sequence is tried from idle, from a pending request and from an assigned unit with a secondary reservation. The write grant is held back for an extra cycle to expose any sequencer that advances without it. A continue with a rejected write in the middle tells the preserved lower half apart from the cleared upper half, and a write with both command bits set shows which one wins.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

    localparam int CFG_W  = 12;
    localparam int HALF_W = CFG_W / 2;

    localparam logic [CFG_W-1:0] RSV_MASK = 12'h330;
    localparam logic [CFG_W-1:0] LOW_MASK = {{(CFG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    typedef struct packed {
        logic       rst;
        logic       cont;
        logic [1:0] rsv_hi;
        logic       ext_addr;
        logic       big_burst;
        logic [1:0] rsv_lo;
        logic       glob_note;
        logic       icv_stat;
        logic       all_stat;
        logic       done_wb;
    } cfg_t;

    typedef enum logic [3:0] {
        S_IDLE, S_REQ, S_ACT, S_CANCEL, S_WR_PRI, S_WR_SEC,
        S_REL_PRI, S_REL_SEC, S_CLEAR
    } seq_st_e;

    typedef enum logic [1:0] {OP_NONE, OP_RESET, OP_CONT, OP_FINISH} op_e;

    typedef struct packed {
        logic wb;
        logic stat;
    } wb_dec_t;

    function automatic cfg_t sanitize(logic [CFG_W-1:0] w);
        cfg_t c;
        c = cfg_t'(w & ~RSV_MASK);
        if (c.rst) c.cont = 1'b0;
        return c;
    endfunction

    function automatic wb_dec_t wb_decide(cfg_t c, logic dn, logic icv);
        wb_dec_t d;
        d.stat = c.all_stat | (c.icv_stat & icv);
        d.wb   = (c.done_wb & (c.glob_note | dn)) | d.stat;
        return d;
    endfunction

endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
    import chan_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             clr_all,
    input  logic             keep_low,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            cfg <= '0;
        end else if (keep_low) begin
            cfg <= cfg_t'(cfg & LOW_MASK);
        end else if (wr_en) begin
            cfg <= sanitize(wr_data);
        end
    end
endmodule

// File: rtl/chan_seq_fsm.sv
module chan_seq_fsm
    import chan_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_rst,
    input  logic cmd_cont,
    input  logic desc_start,
    input  logic eu_gnt,
    input  logic sec_rsv,
    input  logic desc_done,
    input  logic eu_wr_gnt,
    output logic eu_req,
    output logic eu_rel_pri,
    output logic eu_rel_sec,
    output logic eu_wr_req,
    output logic eu_wr_sec,
    output logic fifo_clr,
    output logic resume,
    output logic busy,
    output logic clr_all,
    output logic keep_low,
    output logic done_evt
);
    seq_st_e st, st_nx;
    op_e     op, op_nx;
    logic    sec_held, sec_nx;
    logic    pend;
    op_e     cmd_op;

    assign pend   = cmd_rst | cmd_cont;
    assign cmd_op = cmd_rst ? OP_RESET : OP_CONT;

    always_comb begin
        st_nx  = st;
        op_nx  = op;
        sec_nx = sec_held;
        unique case (st)
            S_IDLE: begin
                if (pend) begin
                    st_nx = S_CLEAR;
                    op_nx = cmd_op;
                end else if (desc_start) begin
                    st_nx = S_REQ;
                end
            end
            S_REQ: begin
                if (pend) begin
                    st_nx = S_CANCEL;
                    op_nx = cmd_op;
                end else if (eu_gnt) begin
                    st_nx  = S_ACT;
                    sec_nx = sec_rsv;
                end
            end
            S_ACT: begin
                if (pend) begin
                    st_nx = S_WR_PRI;
                    op_nx = cmd_op;
                end else if (desc_done) begin
                    st_nx = S_REL_PRI;
                    op_nx = OP_FINISH;
                end
            end
            S_CANCEL: st_nx = S_CLEAR;
            S_WR_PRI: if (eu_wr_gnt) st_nx = sec_held ? S_WR_SEC : S_REL_PRI;
            S_WR_SEC: if (eu_wr_gnt) st_nx = S_REL_PRI;
            S_REL_PRI: begin
                if (sec_held)             st_nx = S_REL_SEC;
                else if (op == OP_FINISH) st_nx = S_IDLE;
                else                      st_nx = S_CLEAR;
            end
            S_REL_SEC: st_nx = (op == OP_FINISH) ? S_IDLE : S_CLEAR;
            S_CLEAR:   st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
        if (st_nx == S_IDLE) begin
            op_nx  = OP_NONE;
            sec_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            op       <= OP_NONE;
            sec_held <= 1'b0;
        end else begin
            st       <= st_nx;
            op       <= op_nx;
            sec_held <= sec_nx;
        end
    end

    assign eu_req     = (st == S_REQ);
    assign eu_rel_pri = (st == S_CANCEL) || (st == S_REL_PRI);
    assign eu_rel_sec = (st == S_REL_SEC);
    assign eu_wr_req  = (st == S_WR_PRI) || (st == S_WR_SEC);
    assign eu_wr_sec  = (st == S_WR_SEC);
    assign busy       = (op == OP_RESET) || (op == OP_CONT);
    assign clr_all    = (st == S_CLEAR) && (op == OP_RESET);
    assign keep_low   = (st == S_CLEAR) && (op == OP_CONT);
    assign fifo_clr   = clr_all;
    assign resume     = keep_low;
    assign done_evt   = (st == S_ACT) && !pend && desc_done;
endmodule

// File: rtl/chan_wb_unit.sv
module chan_wb_unit
    import chan_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_evt,
    input  cfg_t cfg,
    input  logic dn,
    input  logic icv,
    output logic hdr_wb_req,
    output logic hdr_wb_stat
);
    wb_dec_t dec;

    always_comb dec = wb_decide(cfg, dn, icv);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_wb_req  <= 1'b0;
            hdr_wb_stat <= 1'b0;
        end else begin
            hdr_wb_req  <= done_evt & dec.wb;
            hdr_wb_stat <= done_evt & dec.stat;
        end
    end
endmodule

// File: rtl/chan_ctl_seq.sv
module chan_ctl_seq
    import chan_ctl_pkg::*;
#(
    parameter int BURST_SMALL = 64,
    parameter int BURST_LARGE = 128,
    parameter int ADDR_NARROW = 32,
    parameter int ADDR_WIDE   = 36,
    localparam int BW = $clog2(BURST_LARGE + 1),
    localparam int AW = $clog2(ADDR_WIDE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             desc_start,
    input  logic             eu_gnt,
    input  logic             sec_rsv,
    input  logic             desc_done,
    input  logic             desc_dn,
    input  logic             desc_icv,
    output logic             eu_req,
    output logic             eu_rel_pri,
    output logic             eu_rel_sec,
    output logic             eu_wr_req,
    output logic             eu_wr_sec,
    input  logic             eu_wr_gnt,
    output logic             fifo_clr,
    output logic             resume,
    output logic             hdr_wb_req,
    output logic             hdr_wb_stat,
    output logic             busy,
    output logic [BW-1:0]    burst_bytes,
    output logic [AW-1:0]    addr_bits
);
    cfg_t cfg;
    logic clr_all, keep_low, done_evt, wr_ok;

    assign wr_ok = cfg_we && !busy && !cfg.rst && !cfg.cont;

    chan_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .wr_data  (cfg_wdata),
        .clr_all  (clr_all),
        .keep_low (keep_low),
        .cfg      (cfg)
    );

    chan_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_rst    (cfg.rst),
        .cmd_cont   (cfg.cont),
        .desc_start (desc_start),
        .eu_gnt     (eu_gnt),
        .sec_rsv    (sec_rsv),
        .desc_done  (desc_done),
        .eu_wr_gnt  (eu_wr_gnt),
        .eu_req     (eu_req),
        .eu_rel_pri (eu_rel_pri),
        .eu_rel_sec (eu_rel_sec),
        .eu_wr_req  (eu_wr_req),
        .eu_wr_sec  (eu_wr_sec),
        .fifo_clr   (fifo_clr),
        .resume     (resume),
        .busy       (busy),
        .clr_all    (clr_all),
        .keep_low   (keep_low),
        .done_evt   (done_evt)
    );

    chan_wb_unit u_wb (
        .clk         (clk),
        .rst         (rst),
        .done_evt    (done_evt),
        .cfg         (cfg),
        .dn          (desc_dn),
        .icv         (desc_icv),
        .hdr_wb_req  (hdr_wb_req),
        .hdr_wb_stat (hdr_wb_stat)
    );

    assign cfg_rdata   = cfg;
    assign burst_bytes = cfg.big_burst ? BW'(BURST_LARGE) : BW'(BURST_SMALL);
    assign addr_bits   = cfg.ext_addr  ? AW'(ADDR_WIDE)   : AW'(ADDR_NARROW);
endmodule

// File: rtl/chan_ctl_chk.sv
module chan_ctl_chk
    import chan_ctl_pkg::*;
#(
    parameter int BW = 8,
    parameter int AW = 6,
    parameter int BURST_SMALL = 64,
    parameter int BURST_LARGE = 128
) (
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             eu_req,
    input logic             eu_rel_pri,
    input logic             eu_rel_sec,
    input logic             eu_wr_req,
    input logic             eu_wr_sec,
    input logic             eu_wr_gnt,
    input logic             fifo_clr,
    input logic             resume,
    input logic             hdr_wb_req,
    input logic             hdr_wb_stat,
    input logic             busy,
    input logic [BW-1:0]    burst_bytes
);
    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & RSV_MASK) == '0);

    assert_burst_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (burst_bytes == BW'(BURST_SMALL)) || (burst_bytes == BW'(BURST_LARGE)));

    assert_stat_implies_wb_R6: assert property (@(posedge clk) disable iff (rst)
        hdr_wb_stat |-> hdr_wb_req);

    assert_req_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        eu_req |-> !busy);

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (eu_wr_req && !eu_wr_gnt) |=> (eu_wr_req && $stable(eu_wr_sec)));

    assert_rel_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        eu_rel_pri |=> !eu_rel_pri);

    assert_rel_sec_after_pri_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(eu_rel_sec) |-> $past(eu_rel_pri));

    assert_cont_no_fifo_clr_R9: assert property (@(posedge clk) disable iff (rst)
        !(fifo_clr && resume));

    assert_busy_end_clean_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cfg_rdata[CFG_W-1 -: 2] == 2'b00));

    assert_busy_needs_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cfg_rdata[CFG_W-1 -: 2]) != 2'b00));
endmodule

bind chan_ctl_seq chan_ctl_chk #(
    .BW(BW), .AW(AW), .BURST_SMALL(BURST_SMALL), .BURST_LARGE(BURST_LARGE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_rdata   (cfg_rdata),
    .eu_req      (eu_req),
    .eu_rel_pri  (eu_rel_pri),
    .eu_rel_sec  (eu_rel_sec),
    .eu_wr_req   (eu_wr_req),
    .eu_wr_sec   (eu_wr_sec),
    .eu_wr_gnt   (eu_wr_gnt),
    .fifo_clr    (fifo_clr),
    .resume      (resume),
    .hdr_wb_req  (hdr_wb_req),
    .hdr_wb_stat (hdr_wb_stat),
    .busy        (busy),
    .burst_bytes (burst_bytes)
);

// File: tb/tb_chan_ctl_seq.sv
module tb_chan_ctl_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [11:0] cfg_wdata;
    logic [11:0] cfg_rdata;
    logic desc_start, eu_gnt, sec_rsv, desc_done, desc_dn, desc_icv, eu_wr_gnt;
    logic eu_req, eu_rel_pri, eu_rel_sec, eu_wr_req, eu_wr_sec;
    logic fifo_clr, resume, hdr_wb_req, hdr_wb_stat, busy;
    logic [7:0] burst_bytes;
    logic [5:0] addr_bits;

    int n_vec  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    chan_ctl_seq dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .desc_start(desc_start), .eu_gnt(eu_gnt),
        .sec_rsv(sec_rsv), .desc_done(desc_done), .desc_dn(desc_dn),
        .desc_icv(desc_icv), .eu_req(eu_req), .eu_rel_pri(eu_rel_pri),
        .eu_rel_sec(eu_rel_sec), .eu_wr_req(eu_wr_req), .eu_wr_sec(eu_wr_sec),
        .eu_wr_gnt(eu_wr_gnt), .fifo_clr(fifo_clr), .resume(resume),
        .hdr_wb_req(hdr_wb_req), .hdr_wb_stat(hdr_wb_stat), .busy(busy),
        .burst_bytes(burst_bytes), .addr_bits(addr_bits)
    );

    // {done_wb, all_stat, icv_stat, glob_note, desc_dn, desc_icv, exp_wb, exp_stat}
    localparam int NV = 10;
    localparam logic [7:0] VEC [NV] = '{
        8'h0C, 8'h80, 8'h8A, 8'h92, 8'h27, 8'h20, 8'h43, 8'h63, 8'hFF, 8'h10
    };

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic do_reset();
        nxt();
        rst = 1'b1; cfg_we = 0; cfg_wdata = '0; desc_start = 0; eu_gnt = 0;
        sec_rsv = 0; desc_done = 0; desc_dn = 0; desc_icv = 0; eu_wr_gnt = 0;
        nxt(); nxt();
        rst = 1'b0;
    endtask

    task automatic wr(logic [11:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        nxt();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        nxt();
        // R1 reset state
        chk("R1 cfg", cfg_rdata, 0);
        chk("R1 busy", busy, 0);
        chk("R1 req", eu_req, 0);
        chk("R1 strobes", {eu_rel_pri, eu_rel_sec, eu_wr_req, fifo_clr, resume, hdr_wb_req}, 0);
        chk("R1 burst", burst_bytes, 64);
        chk("R1 addr", addr_bits, 32);

        // R5/R6 completion decision table
        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            v = VEC[i];
            wr({8'h00, v[4], v[5], v[6], v[7]});
            desc_start = 1'b1;
            nxt();
            desc_start = 1'b0; eu_gnt = 1'b1; sec_rsv = 1'b0;
            nxt();
            eu_gnt = 1'b0; desc_done = 1'b1; desc_dn = v[3]; desc_icv = v[2];
            nxt();
            desc_done = 1'b0; desc_dn = 0; desc_icv = 0;
            chk($sformatf("R5 wb vec%0d", i), hdr_wb_req, v[1]);
            chk($sformatf("R6 stat vec%0d", i), hdr_wb_stat, v[0]);
            chk($sformatf("R5 rel vec%0d", i), eu_rel_pri, 1);
            nxt();
            chk($sformatf("R5 idle vec%0d", i), {hdr_wb_req, busy, eu_req}, 0);
        end

        // R2, R3, R4: reserved bits and mode bits
        do_reset();
        wr(12'h3F0);
        chk("R2 rsv masked", cfg_rdata, 12'h0C0);
        chk("R3 burst 128", burst_bytes, 128);
        chk("R4 addr 36", addr_bits, 36);

        // R13 reset from idle
        wr(12'h8CF);
        chk("R13 cmd stored", cfg_rdata, 12'h8CF);
        nxt();
        chk("R13 fifo_clr", fifo_clr, 1);
        chk("R12 busy in clear", busy, 1);
        chk("R13 no unit traffic", {eu_wr_req, eu_rel_pri, eu_rel_sec}, 0);
        nxt();
        chk("R13 cfg cleared", cfg_rdata, 0);
        chk("R12 busy end", busy, 0);
        chk("R3 burst back 64", burst_bytes, 64);

        // R10 both command bits
        wr(12'hC00);
        chk("R10 reset wins", cfg_rdata, 12'h800);
        nxt();
        chk("R10 fifo_clr", fifo_clr, 1);
        chk("R10 no resume", resume, 0);
        nxt();
        chk("R10 cfg cleared", cfg_rdata, 0);

        // R7 cancel during request
        desc_start = 1'b1;
        nxt();
        desc_start = 1'b0;
        chk("R7 requesting", eu_req, 1);
        wr(12'h800);
        chk("R7 still req", eu_req, 1);
        nxt();
        chk("R7 release", eu_rel_pri, 1);
        chk("R7 req dropped", eu_req, 0);
        chk("R7 no unit write", eu_wr_req, 0);
        chk("R12 busy cancel", busy, 1);
        nxt();
        chk("R7 clear cycle", fifo_clr, 1);
        nxt();
        chk("R7 idle", {busy, cfg_rdata}, 0);

        // R8 reset with primary and secondary assigned
        desc_start = 1'b1;
        nxt();
        desc_start = 1'b0; eu_gnt = 1'b1; sec_rsv = 1'b1;
        nxt();
        eu_gnt = 1'b0; sec_rsv = 1'b0;
        wr(12'h800);
        chk("R12 not yet busy", busy, 0);
        nxt();
        chk("R8 wr pri", {eu_wr_req, eu_wr_sec}, 2'b10);
        chk("R12 busy", busy, 1);
        nxt();
        chk("R8 wr pri held", {eu_wr_req, eu_wr_sec}, 2'b10);
        eu_wr_gnt = 1'b1;
        nxt();
        eu_wr_gnt = 1'b0;
        chk("R8 wr sec", {eu_wr_req, eu_wr_sec}, 2'b11);
        eu_wr_gnt = 1'b1;
        nxt();
        eu_wr_gnt = 1'b0;
        chk("R8 rel pri", {eu_rel_pri, eu_rel_sec, eu_wr_req}, 3'b100);
        nxt();
        chk("R8 rel sec", {eu_rel_pri, eu_rel_sec}, 2'b01);
        nxt();
        chk("R8 clear", {fifo_clr, busy}, 2'b11);
        nxt();
        chk("R8 idle", {busy, cfg_rdata}, 0);

        // R9 / R11 continue with a write attempt mid-sequence
        wr(12'h0CB);
        desc_start = 1'b1;
        nxt();
        desc_start = 1'b0; eu_gnt = 1'b1; sec_rsv = 1'b0;
        nxt();
        eu_gnt = 1'b0;
        wr(12'h4CB);
        nxt();
        chk("R9 wr pri", eu_wr_req, 1);
        chk("R12 busy cont", busy, 1);
        wr(12'h005);
        chk("R11 write ignored", cfg_rdata, 12'h4CB);
        eu_wr_gnt = 1'b1;
        nxt();
        eu_wr_gnt = 1'b0;
        chk("R9 rel pri", eu_rel_pri, 1);
        nxt();
        chk("R9 resume", resume, 1);
        chk("R9 no fifo_clr", fifo_clr, 0);
        nxt();
        chk("R9 lower kept", cfg_rdata, 12'h00B);
        chk("R9 burst reset", burst_bytes, 64);
        chk("R9 addr reset", addr_bits, 32);
        chk("R12 busy end cont", busy, 0);

        // R11 write accepted again once idle
        wr(12'h001);
        chk("R11 write after idle", cfg_rdata, 12'h001);

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule